// File: doc/BRIEF.md
# Programmable CRC-32 Word Engine

This block computes a running 32-bit CRC over a stream of 32-bit data words, using a polynomial written by software. It sits behind a small register interface and takes data from a valid/ready stream port. Writing the polynomial register starts an internal build of a 256-entry lookup table, at one entry per clock. A status bit reports when the table is ready. Software then writes a seed into the result register, loads a word count, and sets the enable bit with the operating-mode field at calculate. Each accepted word is folded into the CRC as four byte lookups, least significant byte first, using reflected bit order.

When the last counted word has been folded in, a sticky expiry status bit is set. A per-source enable mask gates that bit onto one interrupt line. The stream port applies back-pressure. `s_ready` stays low until the table is built, the enable bit is set with the calculate mode, and words remain in the count. It also stays low while the previous word still has more than one byte lookup to go. A word moves only in a cycle where both `s_valid` and `s_ready` are high. A source that sees `s_ready` low must hold `s_data` steady with `s_valid` high. The result register always shows the running value, and no final inversion is applied.

Top module: `crc_word_engine`

## Requirements
- R1: A write of `reg_wdata` to address 1 (polynomial) while the enable bit is clear and no word is in flight clears status bit 2 (table ready) on the next clock. Status bit 2 is set again exactly 256 clocks after the write edge. `s_ready` stays low while it is clear.
- R2: After reset the control register (address 0), the status register (address 5) and the interrupt-enable register (address 6) read 0, and `irq` and `s_ready` are low.
- R3: The result register (address 2) is loaded with a seed by a write while the block is idle. For each word, the bytes are taken in order from bits 7:0 up to bits 31:24, and each byte updates the value as crc = (crc >> 8) ^ T[(crc ^ byte) & 0xFF]. T is the reflected table of the written polynomial. No final XOR is applied. As an example, polynomial 0xEDB88320 with seed 0xFFFFFFFF and one zero word gives 0xDEBB20E3.
- R4: The count register (address 3) holds the number of words that remain. It drops by one on each accepted word. `s_ready` is low while it reads 0, so a job started with a count of 0 accepts nothing and never sets the expiry bit.
- R5: Status bit 0 (expiry) sets on the clock that completes the fourth byte lookup of the word that took the count to 0. It then stays set until a write to address 5 with bit 0 at 1. A write with bit 0 at 0 leaves it set.
- R6: A write to address 6 sets the enable bits given by bit 0 (expiry) and bit 1 (compare error), and zero bits have no effect. `irq` is high exactly when an enabled status source is set.
- R7: Control bit 0 is the enable bit and bits 2:1 are the mode field, where value 1 means calculate. Status bit 3 (busy) follows the enable bit. `s_ready` can be high only with the enable bit set, mode 1 and the table ready.
- R8: While the enable bit is set, writes to the polynomial, result and count registers are ignored.
- R9: After each accepted word `s_ready` is low for the next three clocks, so a continuous stream moves one word per four clocks. A word offered while `s_ready` is low is not consumed.
- R10: Status bit 1 (compare error) always reads 0. The reload register (address 4) stores a written count and reads it back, and it has no effect on the job.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select, for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| s_valid | input | 1 | Data word offered |
| s_data | input | 32 | Data word |
| s_ready | output | 1 | Engine takes the word this cycle |
| irq | output | 1 | Interrupt: enabled status source set |

## Verification
The hardest situation to bring about is the overlap at a word boundary. There, the last byte lookup of one word lands on the same edge that accepts the next word, and the expiry must wait for the final word rather than the final handshake. The stimulus reaches it by keeping `s_valid` high with random gaps from a seeded generator over several jobs with random polynomials, seeds and lengths. A bit-serial model in the bench recomputes each CRC. A directed run also counts clocks after the last handshake to pin the expiry edge, and the 256-clock table build is timed in the same way.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_POLY   = 3'd1,
    A_RESULT = 3'd2,
    A_COUNT  = 3'd3,
    A_RELOAD = 3'd4,
    A_STATUS = 3'd5,
    A_IEN    = 3'd6
  } reg_sel_e;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_CALC = 2'd1,
    MODE_CMP  = 2'd2,
    MODE_RSV  = 2'd3
  } op_mode_e;

  // status bit positions
  localparam int unsigned ST_EXPIRED = 0;
  localparam int unsigned ST_CMPERR  = 1;
  localparam int unsigned ST_TBLRDY  = 2;
  localparam int unsigned ST_BUSY    = 3;
endpackage

// File: rtl/crc_lut_store.sv
module crc_lut_store #(
  parameter int unsigned CRC_W = 32,
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CRC_W-1:0] poly,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CRC_W-1:0] rd_val,
  output logic             done
);
  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic [CRC_W-1:0] tbl [ENTRIES];
  logic [CRC_W-1:0] poly_l;
  logic [IDX_W-1:0] fill_idx;
  logic             filling;

  function automatic logic [CRC_W-1:0] entry_of(input logic [IDX_W-1:0] i,
                                                input logic [CRC_W-1:0] p);
    logic [CRC_W-1:0] c;
    c = CRC_W'(i);
    for (int b = 0; b < int'(IDX_W); b++) begin
      c = c[0] ? ((c >> 1) ^ p) : (c >> 1);
    end
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filling  <= 1'b0;
      done     <= 1'b0;
      fill_idx <= '0;
      poly_l   <= '0;
    end else if (start) begin
      filling  <= 1'b1;
      done     <= 1'b0;
      fill_idx <= '0;
      poly_l   <= poly;
    end else if (filling) begin
      fill_idx <= fill_idx + 1'b1;
      if (fill_idx == '1) begin
        filling <= 1'b0;
        done    <= 1'b1;
      end
    end
  end

  // storage carries no reset; it is only read once done is set
  always_ff @(posedge clk) begin
    if (filling) tbl[fill_idx] <= entry_of(fill_idx, poly_l);
  end

  assign rd_val = tbl[rd_idx];
endmodule

// File: rtl/crc_byte_engine.sv
module crc_byte_engine #(
  parameter int unsigned CRC_W  = 32,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IDX_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_wr,
  input  logic [CRC_W-1:0] seed_val,
  input  logic             load,
  input  logic [WORD_W-1:0] load_word,
  output logic [IDX_W-1:0] lut_idx,
  input  logic [CRC_W-1:0] lut_val,
  output logic [CRC_W-1:0] crc,
  output logic             idle,
  output logic             last_step
);
  localparam int unsigned LANES = WORD_W / IDX_W;
  localparam int unsigned LW    = $clog2(LANES + 1);

  logic [WORD_W-1:0] sh;
  logic [LW-1:0]     left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc  <= '0;
      sh   <= '0;
      left <= '0;
    end else begin
      if (seed_wr)         crc <= seed_val;
      else if (left != '0) crc <= (crc >> IDX_W) ^ lut_val;

      if (load)            sh <= load_word;
      else if (left != '0) sh <= sh >> IDX_W;

      if (load)            left <= LW'(LANES);
      else if (left != '0) left <= left - 1'b1;
    end
  end

  assign lut_idx   = crc[IDX_W-1:0] ^ sh[IDX_W-1:0];
  assign idle      = (left == '0);
  assign last_step = (left == LW'(1));
endmodule

// File: rtl/crc_word_counter.sv
module crc_word_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] count,
  output logic             zero
);
  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (dec && count != '0) count <= count - 1'b1;
  end

  assign zero = (count == '0);
endmodule

// File: rtl/crc_word_engine.sv
module crc_word_engine
  import crc_eng_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  input  logic              s_valid,
  input  logic [BUS_W-1:0]  s_data,
  output logic              s_ready,
  output logic              irq
);
  localparam int unsigned CRC_W = BUS_W;

  logic             ctrl_en;
  op_mode_e         ctrl_mode;
  logic [CRC_W-1:0] poly_q;
  logic [CNT_W-1:0] reload_q;
  logic [1:0]       ien_q;
  logic             expired;
  logic             cmp_err;
  logic             tbl_done;
  logic             eng_idle;
  logic             last_step;
  logic [IDX_W-1:0] lut_idx;
  logic [CRC_W-1:0] lut_val;
  logic [CRC_W-1:0] crc_val;
  logic [CNT_W-1:0] words_left;
  logic             cnt_zero;
  logic             cfg_ok;
  logic             wr_poly, wr_seed, wr_cnt;
  logic             accept;

  assign cfg_ok  = !ctrl_en && eng_idle;
  assign wr_poly = reg_wr && reg_addr == A_POLY   && cfg_ok;
  assign wr_seed = reg_wr && reg_addr == A_RESULT && cfg_ok;
  assign wr_cnt  = reg_wr && reg_addr == A_COUNT  && cfg_ok;
  assign cmp_err = 1'b0;

  assign s_ready = ctrl_en && ctrl_mode == MODE_CALC && tbl_done &&
                   !cnt_zero && (eng_idle || last_step);
  assign accept  = s_valid && s_ready;
  assign irq     = (expired && ien_q[0]) || (cmp_err && ien_q[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      ctrl_mode <= MODE_OFF;
      poly_q    <= '0;
      reload_q  <= '0;
      ien_q     <= '0;
      expired   <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) begin
        ctrl_en   <= reg_wdata[0];
        ctrl_mode <= op_mode_e'(reg_wdata[2:1]);
      end
      if (wr_poly) poly_q <= reg_wdata;
      if (reg_wr && reg_addr == A_RELOAD) reload_q <= reg_wdata[CNT_W-1:0];
      if (reg_wr && reg_addr == A_IEN) ien_q <= ien_q | reg_wdata[1:0];
      if (last_step && cnt_zero) expired <= 1'b1;
      else if (reg_wr && reg_addr == A_STATUS && reg_wdata[ST_EXPIRED]) expired <= 1'b0;
    end
  end

  crc_lut_store #(.CRC_W(CRC_W), .IDX_W(IDX_W)) u_lut (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (wr_poly),
    .poly   (reg_wdata),
    .rd_idx (lut_idx),
    .rd_val (lut_val),
    .done   (tbl_done)
  );

  crc_byte_engine #(.CRC_W(CRC_W), .WORD_W(BUS_W), .IDX_W(IDX_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .seed_wr   (wr_seed),
    .seed_val  (reg_wdata),
    .load      (accept),
    .load_word (s_data),
    .lut_idx   (lut_idx),
    .lut_val   (lut_val),
    .crc       (crc_val),
    .idle      (eng_idle),
    .last_step (last_step)
  );

  crc_word_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_cnt),
    .load_val (reg_wdata[CNT_W-1:0]),
    .dec      (accept),
    .count    (words_left),
    .zero     (cnt_zero)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:   reg_rdata[2:0] = {ctrl_mode, ctrl_en};
      A_POLY:   reg_rdata = poly_q;
      A_RESULT: reg_rdata = crc_val;
      A_COUNT:  reg_rdata[CNT_W-1:0] = words_left;
      A_RELOAD: reg_rdata[CNT_W-1:0] = reload_q;
      A_STATUS: begin
        reg_rdata[ST_EXPIRED] = expired;
        reg_rdata[ST_CMPERR]  = cmp_err;
        reg_rdata[ST_TBLRDY]  = tbl_done;
        reg_rdata[ST_BUSY]    = ctrl_en;
      end
      A_IEN:    reg_rdata[1:0] = ien_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/crc_word_engine_chk.sv
module crc_word_engine_chk
  import crc_eng_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [BUS_W-1:0]  reg_wdata,
  input logic              s_valid,
  input logic              s_ready,
  input logic              irq,
  input logic              ctrl_en,
  input logic              tbl_done,
  input logic              expired,
  input logic              cmp_err,
  input logic              eng_idle,
  input logic [CNT_W-1:0]  words_left
);
  // R7
  ready_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (ctrl_en && tbl_done));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> (words_left == $past(words_left) - 1'b1));

  // R5
  expired_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !(reg_wr && reg_addr == A_STATUS && reg_wdata[ST_EXPIRED])) |=> expired);

  // R1
  poly_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_POLY && !ctrl_en && eng_idle) |=> !tbl_done);

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (expired || cmp_err));

  // R9
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);
endmodule

bind crc_word_engine crc_word_engine_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .s_valid    (s_valid),
  .s_ready    (s_ready),
  .irq        (irq),
  .ctrl_en    (ctrl_en),
  .tbl_done   (tbl_done),
  .expired    (expired),
  .cmp_err    (cmp_err),
  .eng_idle   (eng_idle),
  .words_left (words_left)
);

// File: tb/crc_word_engine_test.sv
module crc_word_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_ready;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  localparam logic [2:0] RA_CTRL = 3'd0, RA_POLY = 3'd1, RA_RES = 3'd2,
                         RA_CNT = 3'd3, RA_RLD = 3'd4, RA_ST = 3'd5, RA_IEN = 3'd6;

  always #2 clk = ~clk;

  crc_word_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .s_valid(s_valid),
    .s_data(s_data), .s_ready(s_ready), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [31:0] crc_word(input logic [31:0] c, input logic [31:0] p,
                                           input logic [31:0] w);
    for (int b = 0; b < 4; b++) begin
      c = c ^ {24'd0, w[8*b +: 8]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ p) : (c >> 1);
    end
    return c;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    peek(a, v);
  endtask

  // returns 1 ns after the accepting edge
  task automatic push(input logic [31:0] w, input bit gaps);
    if (gaps) repeat ($urandom % 3) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b1; s_data = w;
    #1;
    while (!s_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 s_valid = 1'b0;
  endtask

  task automatic load_poly(input logic [31:0] p);
    wr(RA_POLY, p);
    repeat (257) @(negedge clk);
  endtask

  task automatic run_job(input logic [31:0] p, input logic [31:0] seed, input int n);
    logic [31:0] exp_crc, v, w;
    exp_crc = seed;
    wr(RA_RES, seed);
    wr(RA_CNT, n);
    wr(RA_CTRL, 32'h3);
    for (int i = 0; i < n; i++) begin
      w = $urandom;
      exp_crc = crc_word(exp_crc, p, w);
      push(w, 1'b1);
    end
    repeat (6) @(negedge clk);
    peek(RA_ST, v);
    check(v[0] == 1'b1, "R5 expiry after random job", {31'd0, v[0]}, 32'd1);
    peek(RA_RES, v);
    check(v == exp_crc, "R3 random job result", v, exp_crc);
    peek(RA_CNT, v);
    check(v == 0, "R4 count drained", v, 0);
    wr(RA_CTRL, 32'h0);
    wr(RA_ST, 32'h1);
  endtask

  initial begin
    logic [31:0] v, p, seed;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    peek(RA_CTRL, v); check(v == 0, "R2 control reset", v, 0);
    peek(RA_ST, v);   check(v == 0, "R2 status reset", v, 0);
    peek(RA_IEN, v);  check(v == 0, "R2 ien reset", v, 0);
    check(irq == 0 && s_ready == 0, "R2 irq/ready reset", {30'd0, irq, s_ready}, 0);

    // R10 reload read back, compare error zero
    wr(RA_RLD, 32'h00AB);
    rd(RA_RLD, v); check(v == 32'hAB, "R10 reload readback", v, 32'hAB);

    // R1 table build timing
    wr(RA_POLY, 32'hEDB88320);
    repeat (255) @(negedge clk);
    peek(RA_ST, v); check(v[2] == 1'b0, "R1 table not ready at 255", {31'd0, v[2]}, 0);
    check(s_ready == 1'b0, "R1 ready low during build", {31'd0, s_ready}, 0);
    @(negedge clk);
    peek(RA_ST, v); check(v[2] == 1'b1, "R1 table ready at 256", {31'd0, v[2]}, 1);

    // R3 known vector and R5 expiry edge
    wr(RA_RES, 32'hFFFF_FFFF);
    wr(RA_CNT, 1);
    wr(RA_CTRL, 32'h3);
    peek(RA_ST, v); check(v[3] == 1'b1, "R7 busy follows enable", {31'd0, v[3]}, 1);
    // R8 ignored writes while enabled
    wr(RA_RES, 32'h1234_5678);
    wr(RA_CNT, 9);
    wr(RA_POLY, 32'h0000_0001);
    rd(RA_RES, v); check(v == 32'hFFFF_FFFF, "R8 seed write ignored", v, 32'hFFFF_FFFF);
    peek(RA_CNT, v); check(v == 1, "R8 count write ignored", v, 1);
    peek(RA_ST, v); check(v[2] == 1'b1, "R8 poly write ignored", {31'd0, v[2]}, 1);
    push(32'h0, 1'b0);
    // R9 gap after accept
    #0; check(s_ready == 1'b0, "R9 ready low after accept", {31'd0, s_ready}, 0);
    repeat (4) @(negedge clk);
    peek(RA_ST, v); check(v[0] == 1'b0, "R5 expiry not before 4th lookup", {31'd0, v[0]}, 0);
    @(negedge clk);
    peek(RA_ST, v); check(v[0] == 1'b1, "R5 expiry at 4th lookup", {31'd0, v[0]}, 1);
    check(v[1] == 1'b0, "R10 compare error clear", {31'd0, v[1]}, 0);
    peek(RA_RES, v); check(v == 32'hDEBB20E3, "R3 zero word vector", v, 32'hDEBB20E3);

    // R6 interrupt masking, R5 write-one-to-clear
    check(irq == 1'b0, "R6 irq masked", {31'd0, irq}, 0);
    wr(RA_IEN, 32'h1);
    check(irq == 1'b1, "R6 irq enabled", {31'd0, irq}, 1);
    wr(RA_ST, 32'h0);
    peek(RA_ST, v); check(v[0] == 1'b1, "R5 write zero keeps expiry", {31'd0, v[0]}, 1);
    wr(RA_IEN, 32'h2);
    peek(RA_IEN, v); check(v == 32'h3, "R6 enable set-only", v, 3);
    wr(RA_ST, 32'h1);
    peek(RA_ST, v); check(v[0] == 1'b0, "R5 write one clears", {31'd0, v[0]}, 0);
    check(irq == 1'b0, "R6 irq drops", {31'd0, irq}, 0);
    wr(RA_CTRL, 32'h0);
    peek(RA_ST, v); check(v[3] == 1'b0, "R7 busy clears", {31'd0, v[3]}, 0);

    // R7 non-calculate mode gives no ready
    wr(RA_CNT, 2);
    wr(RA_CTRL, 32'h5);
    s_valid = 1'b1; s_data = 32'hA5A5_A5A5;
    repeat (5) @(negedge clk);
    #1 check(s_ready == 1'b0, "R7 other mode no ready", {31'd0, s_ready}, 0);
    s_valid = 1'b0;
    peek(RA_CNT, v); check(v == 2, "R9 offered word not consumed", v, 2);
    wr(RA_CTRL, 32'h0);

    // R4 zero count job
    wr(RA_CNT, 0);
    wr(RA_CTRL, 32'h3);
    s_valid = 1'b1;
    repeat (8) @(negedge clk);
    #1 check(s_ready == 1'b0, "R4 zero count no ready", {31'd0, s_ready}, 0);
    s_valid = 1'b0;
    peek(RA_ST, v); check(v[0] == 1'b0, "R4 zero count no expiry", {31'd0, v[0]}, 0);
    wr(RA_CTRL, 32'h0);

    // random jobs
    run_job(32'hEDB88320, 32'hFFFF_FFFF, 7);
    for (int j = 0; j < 3; j++) begin
      p = $urandom | 32'h8000_0000;
      seed = $urandom;
      load_poly(p);
      rd(RA_ST, v); check(v[2] == 1'b1, "R1 rebuild done", {31'd0, v[2]}, 1);
      run_job(p, seed, 1 + ($urandom % 12));
    end

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    finish_run();
  end
endmodule